// File: doc/BRIEF.md
# USB OTG Interrupt Aggregator with End-of-Interrupt Gating

This block gathers the event lines of a USB on-the-go controller into one 32-bit pending register and drives a single interrupt request toward the host processor. It has three groups of event inputs: transmit endpoints (endpoint 0 plus four more), receive endpoints 1 to 4, and nine core events. The last core event reports a change in the VBUS drive. Each event that fires latches a bit in the pending register. Software reads that register over a plain 32-bit register bus. Through separate offsets it can force bits in, wipe bits out, and change an enable mask one bit at a time.

The interrupt request rises when an enabled pending bit exists and the end-of-interrupt gate is armed. Raising the request disarms the gate, so the output is a one-cycle request. It stays low, whatever else becomes pending, until software writes any value to the end-of-interrupt offset. A control bit acts as a soft reset of the pending and enable state. A constant identification word can be read at offset 0x00.

Top module: `usbirq_agg`

## Requirements
- R1: After rst_n is held low for a clock edge, the pending register and the mask read 0 and irq_out is low.
- R2: A high event input latches a pending bit at the next clock edge. Transmit event k maps to bit k (k = 0..4). Receive event j (endpoint j+1, j = 0..3) maps to bit 9+j. Core event m maps to bit 16+m (m = 0..8). Bit 8 always reads 0.
- R3: A write to offset 0x24 sets every pending bit whose write-data bit is 1. Write-data bits outside positions 0..4, 9..12 and 16..24 are ignored.
- R4: A write to offset 0x28 clears every pending bit whose write-data bit is 1. If an event hits the same bit in the same cycle, the bit ends up set.
- R5: A write to offset 0x2C loads the mask. A write to 0x30 sets the mask bits written as 1, and a write to 0x34 clears them. Offset 0x2C reads the mask. Mask bits at reserved positions stay 0.
- R6: Offset 0x20 reads the pending register, and offset 0x38 reads the pending register ANDed with the mask.
- R7: irq_out is high in a cycle exactly when the gate is armed and the masked pending value is nonzero. A cycle with irq_out high disarms the gate. A write of any value to 0x3C arms the gate again, and arming takes priority over disarming.
- R8: A write to offset 0x04 with bit 0 = 1 clears the pending register and the mask and arms the gate. Events in that same cycle are dropped. A write with bit 0 = 0 has no effect, and offset 0x04 reads 0.
- R9: Writes to 0x00, 0x20, 0x38 or any unlisted or unaligned offset change nothing, and reads of unlisted offsets return 0.
- R10: Offset 0x00 reads the nonzero constant REV_ID (default 0x4E31_0001).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |
| tx_evt | input | 5 | Transmit endpoint events, endpoint 0 at bit 0 |
| rx_evt | input | 4 | Receive endpoint events for endpoints 1 to 4 |
| core_evt | input | 9 | Core events, VBUS-drive change at bit 8 |
| irq_out | output | 1 | Interrupt request |

## Verification
The embedded properties check these rules on every cycle:
- the priority between a pending event and a clear, and the set and clear effects;
- the three mask operations;
- that the request never stays high into a second cycle without an end-of-interrupt write;
- that a soft reset empties the registers.

Other behaviour is shown only by the bench's scenarios, by comparing against its own register model:
- the field positions of each event group;
- the reserved bit 8;
- the masked read view;
- the behaviour of unlisted offsets and read-only offsets;
- the identification word;
- the full arm and re-arm sequence over long random traffic.

// File: rtl/usbirq_pkg.sv
// Package usbirq_pkg
// Shared offsets, write-strobe type and the field-mask builder for the
// interrupt aggregator. Assumes byte addressing with word-aligned registers.
package usbirq_pkg;

    localparam logic [7:0] OFF_IDENT    = 8'h00;
    localparam logic [7:0] OFF_CTRL     = 8'h04;
    localparam logic [7:0] OFF_PEND     = 8'h20;
    localparam logic [7:0] OFF_PEND_SET = 8'h24;
    localparam logic [7:0] OFF_PEND_CLR = 8'h28;
    localparam logic [7:0] OFF_ENA      = 8'h2C;
    localparam logic [7:0] OFF_ENA_SET  = 8'h30;
    localparam logic [7:0] OFF_ENA_CLR  = 8'h34;
    localparam logic [7:0] OFF_ENA_VIEW = 8'h38;
    localparam logic [7:0] OFF_EOI      = 8'h3C;

    // Decoded write actions; at most one is active in a cycle.
    typedef struct packed {
        logic soft_rst;
        logic pend_set;
        logic pend_clr;
        logic ena_load;
        logic ena_set;
        logic ena_clr;
        logic eoi;
    } wr_act_t;

    // Build the mask of implemented bit positions.
    function automatic logic [31:0] implemented_bits(
        input int unsigned tx_lsb, input int unsigned tx_n,
        input int unsigned rx_base, input int unsigned rx_n,
        input int unsigned core_lsb, input int unsigned core_n);
        logic [31:0] m;
        m = '0;
        for (int unsigned i = 0; i < 32; i++) begin
            if (i >= tx_lsb && i < tx_lsb + tx_n)             m[i] = 1'b1;
            if (i >= rx_base + 1 && i < rx_base + 1 + rx_n)   m[i] = 1'b1;
            if (i >= core_lsb && i < core_lsb + core_n)       m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/usbirq_decode.sv
// Module usbirq_decode
// Turns a bus write into one of the register actions. Assumes a write lasts
// one cycle; unaligned or unlisted offsets produce no action.
module usbirq_decode
    import usbirq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              ctrl_bit0,
    output wr_act_t           act
);

    // Compare the full offset so aliases and unaligned writes decode to nothing.
    always_comb begin
        act          = '0;
        act.soft_rst = we && (addr == ADDR_W'(OFF_CTRL)) && ctrl_bit0;
        act.pend_set = we && (addr == ADDR_W'(OFF_PEND_SET));
        act.pend_clr = we && (addr == ADDR_W'(OFF_PEND_CLR));
        act.ena_load = we && (addr == ADDR_W'(OFF_ENA));
        act.ena_set  = we && (addr == ADDR_W'(OFF_ENA_SET));
        act.ena_clr  = we && (addr == ADDR_W'(OFF_ENA_CLR));
        act.eoi      = we && (addr == ADDR_W'(OFF_EOI));
    end

    // R9
    always_comb begin
        single_action_chk: assert ($onehot0(act));
    end

endmodule

// File: rtl/usbirq_pend_reg.sv
// Module usbirq_pend_reg
// Pending-event register. A hardware event beats a software clear on the
// same bit; soft reset beats everything. Assumes inputs are synchronous.
module usbirq_pend_reg #(
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] IMPL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_evt,
    output logic [DATA_W-1:0] pend_q
);

    logic [DATA_W-1:0] set_bits;
    logic [DATA_W-1:0] clr_bits;
    logic [DATA_W-1:0] pend_d;

    // Gate write data by the action strobes.
    always_comb begin
        set_bits = set_en ? wdata : '0;
        clr_bits = clr_en ? wdata : '0;
    end

    // Next pending value: clear first, then events and sets on top.
    always_comb begin
        pend_d = ((pend_q & ~clr_bits) | set_bits | hw_evt) & IMPL;
    end

    // Hold the pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend_q <= '0;
        else if (wipe) pend_q <= '0;
        else           pend_q <= pend_d;
    end

    // R4
    event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wipe && ((hw_evt & IMPL) != '0)) |=>
            ((pend_q & $past(hw_evt & IMPL)) == $past(hw_evt & IMPL)));

    // R4
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en && hw_evt == '0) |=> ((pend_q & $past(wdata)) == '0));

    // R3
    set_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !wipe) |=> ((pend_q & $past(wdata & IMPL)) == $past(wdata & IMPL)));

    // R8
    wipe_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (pend_q == '0));

endmodule

// File: rtl/usbirq_ena_reg.sv
// Module usbirq_ena_reg
// Interrupt enable mask with load, bit-set and bit-clear writes. Assumes at
// most one of the three write actions is active per cycle.
module usbirq_ena_reg #(
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] IMPL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              load_en,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ena_q
);

    logic [DATA_W-1:0] ena_d;

    // Choose the next mask from the active write action.
    always_comb begin
        ena_d = ena_q;
        if (load_en)     ena_d = wdata;
        else if (set_en) ena_d = ena_q | wdata;
        else if (clr_en) ena_d = ena_q & ~wdata;
        ena_d = ena_d & IMPL;
    end

    // Hold the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)    ena_q <= '0;
        else if (wipe) ena_q <= '0;
        else           ena_q <= ena_d;
    end

    // R5
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !wipe) |=> ((ena_q & $past(wdata & IMPL)) == $past(wdata & IMPL)));

    // R5
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wipe) |=> ((ena_q & $past(wdata)) == '0));

    // R5
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !wipe) |=> (ena_q == $past(wdata & IMPL)));

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !set_en && !clr_en && !wipe) |=> $stable(ena_q));

endmodule

// File: rtl/usbirq_eoi_gate.sv
// Module usbirq_eoi_gate
// Arms and disarms the interrupt request. The request is high while armed
// and something enabled is pending; issuing it disarms the gate until an
// end-of-interrupt write or a soft reset.
module usbirq_eoi_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic eoi,
    input  logic rearm,
    output logic irq
);

    logic armed_q;

    // Request is the armed gate qualified by pending work.
    always_comb begin
        irq = armed_q && pending;
    end

    // Track the arm state; re-arming wins over disarming.
    always_ff @(posedge clk) begin
        if (!rst_n)              armed_q <= 1'b1;
        else if (eoi || rearm)   armed_q <= 1'b1;
        else if (irq)            armed_q <= 1'b0;
    end

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !eoi && !rearm) |=> !irq);

    // R7
    stays_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !pending && !eoi && !rearm && !armed_q) |=> !irq);

    // R7
    rearm_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !rearm) |=> (irq == pending));

endmodule

// File: rtl/usbirq_agg.sv
// Module usbirq_agg
// Top of the interrupt aggregator: packs the event inputs into their pending
// bit positions, decodes register writes, serves reads, and gates the single
// interrupt request by end-of-interrupt writes. Assumes a single-cycle
// write strobe and a combinational read of the addressed register.
module usbirq_agg
    import usbirq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned TX_EPS    = 5,
    parameter int unsigned RX_EPS    = 4,
    parameter int unsigned CORE_EVTS = 9,
    parameter int unsigned TX_LSB    = 0,
    parameter int unsigned RX_BASE   = 8,
    parameter int unsigned CORE_LSB  = 16,
    parameter logic [DATA_W-1:0] REV_ID = 32'h4E31_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [TX_EPS-1:0]    tx_evt,
    input  logic [RX_EPS-1:0]    rx_evt,
    input  logic [CORE_EVTS-1:0] core_evt,
    output logic              irq_out
);

    localparam logic [DATA_W-1:0] IMPL = DATA_W'(implemented_bits(
        TX_LSB, TX_EPS, RX_BASE, RX_EPS, CORE_LSB, CORE_EVTS));
    localparam int unsigned RX_LSB = RX_BASE + 1;

    wr_act_t           act;
    logic [DATA_W-1:0] hw_evt;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] ena_q;
    logic [DATA_W-1:0] pend_view;

    // Place each event input on its pending bit; other positions stay 0.
    for (genvar i = 0; i < DATA_W; i++) begin : g_evt
        if (i >= TX_LSB && i < TX_LSB + TX_EPS) begin : g_tx
            assign hw_evt[i] = tx_evt[i - TX_LSB];
        end else if (i >= RX_LSB && i < RX_LSB + RX_EPS) begin : g_rx
            assign hw_evt[i] = rx_evt[i - RX_LSB];
        end else if (i >= CORE_LSB && i < CORE_LSB + CORE_EVTS) begin : g_core
            assign hw_evt[i] = core_evt[i - CORE_LSB];
        end else begin : g_rsvd
            assign hw_evt[i] = 1'b0;
        end
    end

    usbirq_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr      (bus_addr),
        .we        (bus_we),
        .ctrl_bit0 (bus_wdata[0]),
        .act       (act)
    );

    usbirq_pend_reg #(.DATA_W(DATA_W), .IMPL(IMPL)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .wipe   (act.soft_rst),
        .set_en (act.pend_set),
        .clr_en (act.pend_clr),
        .wdata  (bus_wdata),
        .hw_evt (hw_evt),
        .pend_q (pend_q)
    );

    usbirq_ena_reg #(.DATA_W(DATA_W), .IMPL(IMPL)) u_ena (
        .clk     (clk),
        .rst_n   (rst_n),
        .wipe    (act.soft_rst),
        .load_en (act.ena_load),
        .set_en  (act.ena_set),
        .clr_en  (act.ena_clr),
        .wdata   (bus_wdata),
        .ena_q   (ena_q)
    );

    // Enabled view of the pending bits.
    always_comb begin
        pend_view = pend_q & ena_q;
    end

    usbirq_eoi_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (|pend_view),
        .eoi     (act.eoi),
        .rearm   (act.soft_rst),
        .irq     (irq_out)
    );

    // Select read data by offset; unlisted offsets read 0.
    always_comb begin
        unique case (bus_addr)
            ADDR_W'(OFF_IDENT):    bus_rdata = REV_ID;
            ADDR_W'(OFF_PEND):     bus_rdata = pend_q;
            ADDR_W'(OFF_ENA):      bus_rdata = ena_q;
            ADDR_W'(OFF_ENA_VIEW): bus_rdata = pend_view;
            default:               bus_rdata = '0;
        endcase
    end

    // R2
    tx0_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_evt[0] && !act.soft_rst) |=> pend_q[TX_LSB]);

    // R2
    core_top_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_evt[CORE_EVTS-1] && !act.soft_rst) |=> pend_q[CORE_LSB + CORE_EVTS - 1]);

    // R8
    soft_reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act.soft_rst |=> (!irq_out && ena_q == '0));

    // R7
    irq_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (pend_view != '0));

endmodule

// File: tb/usbirq_agg_test.sv
module usbirq_agg_test;

    localparam logic [31:0] IMPL   = 32'h01FF_1E1F;
    localparam logic [31:0] REV_ID = 32'h4E31_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  tx_evt = '0;
    logic [3:0]  rx_evt = '0;
    logic [8:0]  core_evt = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_pend = '0;
    logic [31:0] m_ena  = '0;
    logic        m_armed = 1'b1;

    always #5 clk = ~clk;

    usbirq_agg uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
        .rx_evt(rx_evt), .core_evt(core_evt), .irq_out(irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00:   return REV_ID;
            8'h20:   return m_pend;
            8'h2C:   return m_ena;
            8'h38:   return m_pend & m_ena;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00:   return "R10";
            8'h04:   return "R8";
            8'h20:   return "R2";
            8'h2C:   return "R5";
            8'h38:   return "R6";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [31:0] pack(input logic [4:0] t, input logic [3:0] r, input logic [8:0] c);
        return 32'(t) | (32'(r) << 9) | (32'(c) << 16);
    endfunction

    // One clock cycle with the given inputs; model advances, request checked.
    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input logic [4:0] t, input logic [3:0] r, input logic [8:0] c);
        logic [31:0] np, ne;
        logic        na;
        logic        fire;
        bus_we = we; bus_addr = a; bus_wdata = d;
        tx_evt = t; rx_evt = r; core_evt = c;
        fire = m_armed && ((m_pend & m_ena) != 0);
        np = m_pend; ne = m_ena; na = m_armed;
        if (we && a == 8'h04 && d[0]) begin
            np = 0; ne = 0; na = 1'b1;
        end else begin
            if (we && a == 8'h28) np = np & ~d;
            if (we && a == 8'h24) np = np | d;
            np = (np | pack(t, r, c)) & IMPL;
            if (we && a == 8'h2C) ne = d & IMPL;
            if (we && a == 8'h30) ne = (ne | d) & IMPL;
            if (we && a == 8'h34) ne = ne & ~d;
            if (we && a == 8'h3C) na = 1'b1;
            else if (fire) na = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; tx_evt = '0; rx_evt = '0; core_evt = '0;
        m_pend = np; m_ena = ne; m_armed = na;
        check("R7", 32'(irq_out), 32'(m_armed && ((m_pend & m_ena) != 0)));
    endtask

    task automatic idle();
        step(1'b0, 8'h00, 32'h0, 5'h0, 4'h0, 9'h0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 5'h0, 4'h0, 9'h0);
    endtask

    task automatic rd(input logic [7:0] a);
        bus_we = 1'b0; bus_addr = a;
        #1;
        check(tag_of(a), bus_rdata, exp_read(a));
    endtask

    function automatic logic [7:0] pick_addr(input int unsigned k);
        case (k % 14)
            0: return 8'h00;  1: return 8'h04;  2: return 8'h20;  3: return 8'h24;
            4: return 8'h28;  5: return 8'h2C;  6: return 8'h30;  7: return 8'h34;
            8: return 8'h38;  9: return 8'h3C; 10: return 8'h40; 11: return 8'h22;
            12: return 8'h08; default: return 8'hFC;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", 32'(irq_out), 32'h0);
        rd(8'h20); rd(8'h2C);
        // R10 identification word
        rd(8'h00);
        check("R10", bus_rdata, REV_ID);

        // R2 field positions of each event group
        step(1'b0, 8'h00, 0, 5'b10001, 4'h0, 9'h0);
        rd(8'h20); check("R2", bus_rdata, 32'h0000_0011);
        step(1'b0, 8'h00, 0, 5'h0, 4'hF, 9'h0);
        rd(8'h20); check("R2", bus_rdata, 32'h0000_1E11);
        step(1'b0, 8'h00, 0, 5'h0, 4'h0, 9'h1FF);
        rd(8'h20); check("R2", bus_rdata, 32'h01FF_1E11);

        // R4 clear all while tx event 0 fires: event wins
        step(1'b1, 8'h28, 32'hFFFF_FFFF, 5'b00001, 4'h0, 9'h0);
        rd(8'h20); check("R4", bus_rdata, 32'h0000_0001);
        wr(8'h28, 32'h1);
        rd(8'h20); check("R4", bus_rdata, 32'h0);

        // R3 set through software, reserved bits ignored
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h20); check("R3", bus_rdata, IMPL);
        wr(8'h28, 32'hFFFF_FFFF);

        // R5 mask operations
        wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h2C); check("R5", bus_rdata, IMPL);
        wr(8'h34, 32'h0100_0001);
        rd(8'h2C); check("R5", bus_rdata, 32'h00FF_1E1E);
        wr(8'h2C, 32'h0);
        wr(8'h30, 32'h0000_0003);
        rd(8'h2C); check("R5", bus_rdata, 32'h0000_0003);

        // R6 masked view
        wr(8'h24, 32'h0000_0206);
        rd(8'h38); check("R6", bus_rdata, 32'h0000_0002);
        check("R7", 32'(irq_out), 32'h1);
        idle();
        check("R7", 32'(irq_out), 32'h0);
        step(1'b0, 8'h00, 0, 5'b00001, 4'h0, 9'h0);
        check("R7", 32'(irq_out), 32'h0);
        wr(8'h3C, 32'h0);
        check("R7", 32'(irq_out), 32'h1);
        idle();
        check("R7", 32'(irq_out), 32'h0);

        // R9 read-only and unlisted offsets
        wr(8'h20, 32'h0);
        wr(8'h38, 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h40, 32'hFFFF_FFFF);
        wr(8'h25, 32'hFFFF_FFFF);
        rd(8'h20); check("R9", bus_rdata, 32'h0000_0207);
        rd(8'h40); check("R9", bus_rdata, 32'h0);

        // R8 control bit 0 clear has no effect, bit 0 set wipes state
        wr(8'h04, 32'hFFFF_FFFE);
        rd(8'h20); check("R8", bus_rdata, 32'h0000_0207);
        rd(8'h04); check("R8", bus_rdata, 32'h0);
        step(1'b1, 8'h04, 32'h1, 5'h1F, 4'hF, 9'h1FF);
        rd(8'h20); check("R8", bus_rdata, 32'h0);
        rd(8'h2C); check("R8", bus_rdata, 32'h0);
        wr(8'h2C, 32'h1);
        step(1'b0, 8'h00, 0, 5'h1, 4'h0, 9'h0);
        check("R8", 32'(irq_out), 32'h1);

        // Random traffic checked against the model
        for (int n = 0; n < 3000; n++) begin
            int unsigned op;
            logic [31:0] d;
            logic [4:0] t;
            logic [3:0] r;
            logic [8:0] c;
            logic [7:0] a;
            op = $urandom % 16;
            d  = $urandom;
            t  = ($urandom % 4 == 0) ? 5'($urandom) : 5'h0;
            r  = ($urandom % 5 == 0) ? 4'($urandom) : 4'h0;
            c  = ($urandom % 6 == 0) ? 9'($urandom) : 9'h0;
            a  = pick_addr($urandom);
            if (op < 8 && !(a == 8'h04 && ($urandom % 6 != 0)))
                step(1'b1, a, d, t, r, c);
            else
                step(1'b0, 8'h00, 0, t, r, c);
            rd(pick_addr($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule